// File: doc/BRIEF.md
# Circular Multi-Tap Address Generator

This block drives the addressing side of one DMA channel whose memory region is used as a circular buffer. The buffer length can be any integer from 1 up to the width limit; it does not have to be a power of two. Each per-sample trigger starts a short burst on the address stream. The first beat is a write address at the current head position. After it comes one read address per configured tap. Each read address is the head position minus that tap's delay, wrapped inside the buffer.

Software (or a neighbouring control block) sets the region's base address, its length and how many taps to use. It fills a small delay table through a simple write port. It then pulses the trigger once per sample period. A downstream mover takes the beats through a valid/ready handshake and moves the data itself. When the last beat of a burst has been accepted, the head moves forward by one place and a completion pulse is raised.

Top module: `circ_tap_addrgen`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` and `done` are low and the head position is 0. The first burst after reset therefore writes at `cfg_base`.
- R2: A trigger seen while idle with a nonzero `cfg_len` starts a burst. On the next cycle `out_valid` is high. The first beat has `out_wr`=1 (1 = write, 0 = read) and its address is base plus head.
- R3: After the write beat, one read beat (`out_wr`=0) is emitted for each tap, in table order from entry 0 upward. Tap k reads at base + ((head − delay[k]) mod length).
- R4: The modulo step needs no divider. When head < delay, the length is added back. Every address lies in [base, base+length), for any length including non-powers of two, as long as each delay is below the length.
- R5: When the last beat of a burst is accepted, the head advances by one. It returns to 0 when it reaches the length.
- R6: `done` is high for exactly one cycle: the cycle after the final beat of a burst is accepted.
- R7: While `out_valid` is high and `out_ready` is low, the beat holds. `out_valid`, `out_addr` and `out_wr` do not change until the beat is accepted.
- R8: Delay-table writes made while a burst is running do not affect that burst. They are used from the next trigger onward.
- R9: A trigger is ignored while a burst is in progress, and also when `cfg_len` is 0. An ignored trigger produces no beats, no `done` and no head movement.
- R10: Base, length and tap count are sampled at the trigger. Changing them mid-burst has no effect on that burst. If the head is not below the newly sampled length, the head restarts at 0.
- R11: A tap count of 0 gives a write-only burst. A tap count above the table size is treated as the table size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | ADDR_W | Region base address |
| cfg_len | input | LEN_W | Buffer length in words |
| cfg_taps | input | CNT_W | Number of read taps per burst |
| tbl_wr_en | input | 1 | Delay-table write strobe |
| tbl_wr_idx | input | IDX_W | Delay-table entry to write |
| tbl_wr_delay | input | LEN_W | Delay value to store |
| trigger | input | 1 | Per-sample start pulse |
| out_valid | output | 1 | Address beat available |
| out_ready | input | 1 | Consumer accepts the beat |
| out_addr | output | ADDR_W | Beat address |
| out_wr | output | 1 | 1 = write beat, 0 = read beat |
| done | output | 1 | One-cycle burst completion pulse |

## Verification
The main stimulus is a long run of bursts with random lengths, delays, tap counts and ready patterns. Because the head walks through the whole buffer, both the no-wrap and the wrap-around branches of the read offset are reached, and stalls on arbitrary beats expose any address that drifts while held.

Directed bursts cover the following cases:
- A short non-power-of-two length, which separates true modulo wrapping from masking.
- Tap counts of zero and of more than the table holds, which separate the write-only path and the clamping path from a normal burst.
- Table and configuration changes, plus extra triggers, in the middle of a burst. These show whether the sampled copies shield the running burst.
- A shrinking length and a zero length, which check the head restart and the rule that a trigger is ignored.

// File: rtl/circ_tap_pkg.sv
// Shared types for the circular multi-tap address generator.
package circ_tap_pkg;
    // Burst sequencer states: idle, emitting the write beat, emitting read beats.
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_WRITE = 2'd1,
        SEQ_READ  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/ctap_table.sv
// Delay table with two banks. Writes always land in the staging bank.
// On 'latch' (burst start) the staging bank is copied into the working
// bank. The running burst reads only the working bank.
// Assumes: wr_idx < MAX_TAPS.
module ctap_table #(
    parameter int MAX_TAPS = 16,
    parameter int LEN_W    = 12,
    localparam int IDX_W   = $clog2(MAX_TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [LEN_W-1:0] wr_delay,
    input  logic             latch,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [LEN_W-1:0] rd_delay
);
    logic [LEN_W-1:0] stage_q [MAX_TAPS];
    logic [LEN_W-1:0] work_q  [MAX_TAPS];

    for (genvar i = 0; i < MAX_TAPS; i++) begin : g_entry
        // Staging entry: take a software write aimed at this index.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage_q[i] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(i)))
                stage_q[i] <= wr_delay;
        end

        // Working entry: refreshed from staging only when a burst starts.
        always_ff @(posedge clk) begin
            if (!rst_n)
                work_q[i] <= '0;
            else if (latch)
                work_q[i] <= stage_q[i];
        end
    end

    // Read port: combinational lookup for the current tap.
    always_comb rd_delay = work_q[rd_idx];
endmodule

// File: rtl/ctap_modsub.sv
// Computes (head - delay) mod len for any len, without a divider.
// One subtraction; if it borrows, len is added back.
// Assumes: head < len and delay < len.
module ctap_modsub #(
    parameter int LEN_W = 12
) (
    input  logic [LEN_W-1:0] head,
    input  logic [LEN_W-1:0] delay,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] offset
);
    logic [LEN_W:0] diff;

    // Wrap: subtract with borrow out, then add the length back on underflow.
    always_comb begin
        diff = {1'b0, head} - {1'b0, delay};
        if (diff[LEN_W])
            offset = diff[LEN_W-1:0] + len;
        else
            offset = diff[LEN_W-1:0];
    end
endmodule

// File: rtl/ctap_head.sv
// Head position of the circular buffer.
// - At burst start, the head goes back to 0 if it is not below the newly
//   sampled length.
// - On 'advance' it steps by one and wraps to 0 at the sampled length.
// Assumes: start and advance are never high in the same cycle.
module ctap_head #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             advance,
    input  logic [LEN_W-1:0] len_q,
    output logic [LEN_W-1:0] head
);
    logic [LEN_W:0]   inc;
    logic [LEN_W-1:0] head_nxt;

    // Increment with wrap-around at the sampled buffer length.
    always_comb begin
        inc      = {1'b0, head} + 1'b1;
        head_nxt = (inc == {1'b0, len_q}) ? '0 : inc[LEN_W-1:0];
    end

    // Head register: reset, restart on length shrink, or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            head <= '0;
        else if (start && (head >= cfg_len))
            head <= '0;
        else if (advance)
            head <= head_nxt;
    end
endmodule

// File: rtl/ctap_seq.sv
// Burst sequencer. It emits one write beat, then ntaps read beats, each
// held until accepted. 'start' marks the accepted trigger. 'finish' marks
// acceptance of the final beat.
// Assumes: ntaps is already clamped to MAX_TAPS and stable during a burst.
module ctap_seq
    import circ_tap_pkg::*;
#(
    parameter int MAX_TAPS = 16,
    localparam int IDX_W   = $clog2(MAX_TAPS),
    localparam int CNT_W   = $clog2(MAX_TAPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_ok,
    input  logic [CNT_W-1:0] ntaps,
    input  logic             ready,
    output logic             valid,
    output logic             is_wr,
    output logic [IDX_W-1:0] tap_idx,
    output logic             start,
    output logic             finish
);
    seq_state_e state_q;
    logic       accept;
    logic       last_rd;

    // Handshake and end-of-burst decode.
    always_comb begin
        valid   = (state_q != SEQ_IDLE);
        is_wr   = (state_q == SEQ_WRITE);
        accept  = valid && ready;
        start   = (state_q == SEQ_IDLE) && trig_ok;
        last_rd = (CNT_W'(tap_idx) == (ntaps - 1'b1));
        finish  = accept && (((state_q == SEQ_WRITE) && (ntaps == '0)) ||
                             ((state_q == SEQ_READ) && last_rd));
    end

    // State register: idle -> write -> reads -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            case (state_q)
                SEQ_IDLE:  if (trig_ok) state_q <= SEQ_WRITE;
                SEQ_WRITE: if (accept)  state_q <= (ntaps == '0) ? SEQ_IDLE : SEQ_READ;
                SEQ_READ:  if (accept && last_rd) state_q <= SEQ_IDLE;
                default:   state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Tap index: cleared at start, stepped after each accepted read beat.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tap_idx <= '0;
        else if (start)
            tap_idx <= '0;
        else if ((state_q == SEQ_READ) && accept && !last_rd)
            tap_idx <= tap_idx + 1'b1;
    end
endmodule

// File: rtl/circ_tap_addrgen.sv
// Address generator for one DMA channel that uses a memory region as a
// circular buffer of any length. On each accepted trigger it emits:
// - a write beat at base+head;
// - one read beat per tap at base+((head-delay) mod len);
// then advances the head and pulses done.
// Assumes: ADDR_W >= LEN_W, every delay used is below the length, and the
// bus address wraps modulo 2**ADDR_W.
module circ_tap_addrgen #(
    parameter int ADDR_W   = 16,
    parameter int LEN_W    = 12,
    parameter int MAX_TAPS = 16,
    localparam int IDX_W   = $clog2(MAX_TAPS),
    localparam int CNT_W   = $clog2(MAX_TAPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [CNT_W-1:0]  cfg_taps,
    input  logic              tbl_wr_en,
    input  logic [IDX_W-1:0]  tbl_wr_idx,
    input  logic [LEN_W-1:0]  tbl_wr_delay,
    input  logic              trigger,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_wr,
    output logic              done
);
    localparam int PAD_W = ADDR_W - LEN_W;

    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  len_q;
    logic [CNT_W-1:0]  ntaps_q;
    logic [CNT_W-1:0]  taps_clamped;
    logic              trig_ok;
    logic              start;
    logic              finish;
    logic [IDX_W-1:0]  tap_idx;
    logic [LEN_W-1:0]  tap_delay;
    logic [LEN_W-1:0]  head;
    logic [LEN_W-1:0]  rd_off;
    logic [LEN_W-1:0]  beat_off;

    // Trigger qualification and tap-count clamp.
    always_comb begin
        trig_ok      = trigger && (cfg_len != '0);
        taps_clamped = (cfg_taps > CNT_W'(MAX_TAPS)) ? CNT_W'(MAX_TAPS) : cfg_taps;
    end

    // Burst configuration sampled at the accepted trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            len_q   <= '0;
            ntaps_q <= '0;
        end else if (start) begin
            base_q  <= cfg_base;
            len_q   <= cfg_len;
            ntaps_q <= taps_clamped;
        end
    end

    // Completion pulse, one cycle after the final beat is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else
            done <= finish;
    end

    ctap_seq #(.MAX_TAPS(MAX_TAPS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_ok (trig_ok),
        .ntaps   (ntaps_q),
        .ready   (out_ready),
        .valid   (out_valid),
        .is_wr   (out_wr),
        .tap_idx (tap_idx),
        .start   (start),
        .finish  (finish)
    );

    ctap_table #(.MAX_TAPS(MAX_TAPS), .LEN_W(LEN_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr_en),
        .wr_idx   (tbl_wr_idx),
        .wr_delay (tbl_wr_delay),
        .latch    (start),
        .rd_idx   (tap_idx),
        .rd_delay (tap_delay)
    );

    ctap_head #(.LEN_W(LEN_W)) u_head (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .cfg_len (cfg_len),
        .advance (finish),
        .len_q   (len_q),
        .head    (head)
    );

    ctap_modsub #(.LEN_W(LEN_W)) u_modsub (
        .head   (head),
        .delay  (tap_delay),
        .len    (len_q),
        .offset (rd_off)
    );

    // Beat address: head for the write beat, wrapped tap offset for reads.
    always_comb begin
        beat_off = out_wr ? head : rd_off;
        out_addr = base_q + {{PAD_W{1'b0}}, beat_off};
    end
endmodule

// File: rtl/ctap_checker.sv
// Protocol and range checks for circ_tap_addrgen, attached with bind.
module ctap_checker #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_wr,
    input logic              done,
    input logic [ADDR_W-1:0] base_q,
    input logic [LEN_W-1:0]  len_q
);
    logic [ADDR_W-1:0] rel;
    always_comb rel = out_addr - base_q;

    // R1: reset leaves the stream idle and done low.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !done));

    // R2: every burst opens with the write beat.
    p_first_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_wr);

    // R4: every emitted address lies inside the region.
    p_in_region_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (rel < {{(ADDR_W-LEN_W){1'b0}}, len_q}));

    // R6: done lasts one cycle.
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: done follows an accepted beat.
    p_done_after_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid && out_ready));

    // R7: a stalled beat holds its address and direction.
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_wr)));
endmodule

bind circ_tap_addrgen ctap_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_wr    (out_wr),
    .done      (done),
    .base_q    (base_q),
    .len_q     (len_q)
);

// File: tb/circ_tap_addrgen_tb.sv
module circ_tap_addrgen_tb;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 12;
    localparam int NT     = 16;
    localparam int IDX_W  = 4;
    localparam int CNT_W  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [LEN_W-1:0]  cfg_len = '0;
    logic [CNT_W-1:0]  cfg_taps = '0;
    logic              tbl_wr_en = 1'b0;
    logic [IDX_W-1:0]  tbl_wr_idx = '0;
    logic [LEN_W-1:0]  tbl_wr_delay = '0;
    logic              trigger = 1'b0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [ADDR_W-1:0] out_addr;
    logic              out_wr;
    logic              done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int m_head = 0;
    int m_shadow [NT];
    int m_active [NT];

    always #10 clk = ~clk;

    circ_tap_addrgen u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_len(cfg_len),
        .cfg_taps(cfg_taps), .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
        .tbl_wr_delay(tbl_wr_delay), .trigger(trigger), .out_valid(out_valid),
        .out_ready(out_ready), .out_addr(out_addr), .out_wr(out_wr), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int wrap_off(input int head, input int dly, input int len);
        return (head >= dly) ? head - dly : head + len - dly;
    endfunction

    function automatic int mk_addr(input int base, input int off);
        return (base + off) & 16'hFFFF;
    endfunction

    task automatic tbl_write(input int idx, input int dly);
        tbl_wr_en = 1'b1; tbl_wr_idx = IDX_W'(idx); tbl_wr_delay = LEN_W'(dly);
        m_shadow[idx] = dly;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    task automatic load_table(input int maxd);
        for (int i = 0; i < NT; i++) tbl_write(i, $urandom % maxd);
    endtask

    // One burst: trigger, collect beats with a random ready, check done and head.
    task automatic run_burst(input int base, input int len, input int taps,
                             input bit perturb, input int stall_pct);
        int n, sb, sl, k;
        bit rdy;
        int prev_addr;
        bit stalled;
        cfg_base = ADDR_W'(base); cfg_len = LEN_W'(len); cfg_taps = CNT_W'(taps);
        trigger = 1'b1;
        n = (taps > NT) ? NT : taps;
        if (m_head >= len) m_head = 0;
        sb = base; sl = len;
        for (int i = 0; i < NT; i++) m_active[i] = m_shadow[i];
        @(negedge clk);
        trigger = perturb;           // R9: extra trigger while busy
        k = 0; stalled = 1'b0; prev_addr = 0;
        while (k <= n) begin
            tbl_wr_en = 1'b0;
            chk(out_valid == 1'b1, "R2 valid during burst", int'(out_valid), 1);
            if (k == 0) begin
                chk(out_wr == 1'b1, "R2 write beat flag", int'(out_wr), 1);
                chk(int'(out_addr) == mk_addr(sb, m_head), "R2 R5 write address",
                    int'(out_addr), mk_addr(sb, m_head));
            end else begin
                int e;
                e = mk_addr(sb, wrap_off(m_head, m_active[k-1], sl));
                chk(out_wr == 1'b0, "R3 read beat flag", int'(out_wr), 0);
                chk(int'(out_addr) == e, "R3 R4 R8 R10 read address", int'(out_addr), e);
            end
            if (stalled)
                chk(int'(out_addr) == prev_addr, "R7 stalled address held",
                    int'(out_addr), prev_addr);
            rdy = (($urandom % 100) >= stall_pct);
            out_ready = rdy;
            if (perturb && k == 1) begin
                cfg_base = ADDR_W'($urandom);          // R10
                cfg_len  = LEN_W'(17 + $urandom % 40);
                cfg_taps = CNT_W'($urandom % 17);
                tbl_wr_en = 1'b1; tbl_wr_idx = 4'd0;   // R8
                tbl_wr_delay = LEN_W'(m_shadow[0] == 16 ? 3 : m_shadow[0] + 1);
                m_shadow[0] = int'(tbl_wr_delay);
            end
            prev_addr = int'(out_addr);
            stalled = !rdy;
            @(negedge clk);
            if (rdy) k++;
        end
        tbl_wr_en = 1'b0; out_ready = 1'b0; trigger = 1'b0;
        chk(done == 1'b1, "R6 done after last beat", int'(done), 1);
        chk(out_valid == 1'b0, "R9 no restart from busy trigger", int'(out_valid), 0);
        m_head = (m_head + 1 == sl) ? 0 : m_head + 1;
        @(negedge clk);
        chk(done == 1'b0, "R6 done one cycle", int'(done), 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NT; i++) begin m_shadow[i] = 0; m_active[i] = 0; end
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid low in reset", int'(out_valid), 0);
        chk(done == 1'b0, "R1 done low in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 idle after reset", int'(out_valid), 0);

        // R4: non-power-of-two length 13, delays chosen to underflow.
        for (int i = 0; i < NT; i++) tbl_write(i, (i * 5 + 3) % 13);
        for (int s = 0; s < 15; s++) run_burst(16'h0100, 13, 4, 1'b0, 30);

        // R11: write-only burst and over-range tap count.
        run_burst(16'h0200, 13, 0, 1'b0, 0);
        run_burst(16'h0200, 13, 25, 1'b0, 20);

        // R5: length 7 wraps the head several times.
        load_table(7);
        for (int s = 0; s < 10; s++) run_burst(16'hFFF8, 7, 3, 1'b0, 25);

        // R10: grow then shrink the length below the head.
        load_table(17);
        for (int s = 0; s < 9; s++) run_burst(16'h0400, 30, 2, 1'b0, 0);
        load_table(5);
        run_burst(16'h0400, 5, 3, 1'b0, 0);

        // R9: a trigger with zero length is ignored.
        cfg_len = '0; trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
        chk(out_valid == 1'b0, "R9 zero length ignored", int'(out_valid), 0);
        @(negedge clk);
        chk(done == 1'b0, "R9 no done on zero length", int'(done), 0);
        run_burst(16'h0400, 5, 1, 1'b0, 0);    // head unchanged by ignored trigger

        // Random mix with mid-burst table and config changes (R8, R10, R9).
        load_table(17);
        for (int s = 0; s < 60; s++)
            run_burst(int'($urandom % 65536), 17 + int'($urandom % 40),
                      int'($urandom % 18), ($urandom % 3) == 0, int'($urandom % 50));

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule